// File: doc/BRIEF.md
# Two-Hand Clock Frame Reclaimer

The block tracks a small table of physical page frames. Each frame has four state bits: a referenced flag, a modified flag, a flag saying the frame is on the free list, and a flag saying a writeback is in flight. Two circular hands sweep the table at a fixed spacing. The clearing hand runs `HAND_GAP` frames ahead and drops the referenced flag of every frame it passes. The reclaiming hand follows behind it. A frame that is still unreferenced when the reclaiming hand reaches it is released. If it is clean, it goes out on a free-list stream. If it is modified, it goes out on a writeback-request stream.

Reference notifications (read or write) and writeback-completion notifications are plain pulses that carry a frame number. The two outputs are valid/ready streams. The hands advance only while `scan_en` is high. They hold still while the stream that the current candidate needs is not ready. A candidate's `*_valid` normally stays high until it is accepted. It drops only if `scan_en` falls or a reference hits that frame; in either case no transfer happens in that cycle. `*_valid` never depends on `*_ready`.

Top module: `clock_reclaimer`

## Requirements
- R1: After reset every frame has all four flags clear. The reclaiming hand is at frame 0 and the clearing hand is at frame `HAND_GAP`. Neither output is valid while `scan_en` is low.
- R2: A reference sets the frame's referenced flag and removes its free-list mark. A write reference also sets its modified flag.
- R3: When the hands advance, the clearing hand drops the referenced flag of its frame. A reference to that same frame in the same cycle wins, so the flag stays set.
- R4: An unreferenced, clean, unmarked frame under the reclaiming hand raises `free_valid` with `free_frame` equal to that frame. On acceptance the frame is marked as on the free list and the hands advance.
- R5: An unreferenced, modified frame with no writeback in flight raises `wb_valid` with `wb_frame` equal to that frame, and does not raise `free_valid`. On acceptance the frame is marked as having a writeback in flight.
- R6: A writeback-done pulse clears the frame's modified and in-flight flags, so the frame can be freed on a later pass. A write reference in the same cycle keeps it modified.
- R7: The reclaiming hand passes over frames that are referenced, already on the free list, or have a writeback in flight, and produces no output for them.
- R8: While the stream needed for the current candidate is not ready, neither hand moves and the candidate stays offered.
- R9: With `scan_en` low the hands do not move and no output is valid.
- R10: Otherwise both hands advance by one frame per cycle. They wrap from `NFRAMES-1` to 0 and keep their spacing.
- R11: A reference to the reclaiming hand's frame in the same cycle makes that frame count as referenced, so it is skipped.
- R12: `free_valid` and `wb_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Lets the hands sweep |
| ref_valid | input | 1 | Reference notification strobe |
| ref_frame | input | FW | Referenced frame number |
| ref_write | input | 1 | Reference is a write |
| wb_done_valid | input | 1 | Writeback completion strobe |
| wb_done_frame | input | FW | Frame whose writeback completed |
| free_valid | output | 1 | Free-list push offered |
| free_ready | input | 1 | Free list accepts a push |
| free_frame | output | FW | Frame being freed |
| wb_valid | output | 1 | Writeback request offered |
| wb_ready | input | 1 | Writeback queue accepts a request |
| wb_frame | output | FW | Frame needing writeback |

## Verification
A corrupted flag shows up at the ports when the reclaiming hand next reaches that frame, which takes at most `NFRAMES` advancing cycles. A stuck referenced flag hides the frame from both streams. A lost modified flag sends a dirty frame to the free list instead of the writeback stream. A lost free-list mark pushes the same frame twice. A hand that slips or skips a step breaks the strict frame order of accepted items. The bench runs a model built from the requirements next to the design and compares every offered item and every accepted item against it, cycle by cycle.

// File: rtl/reclaim_pkg.sv
package reclaim_pkg;
  typedef enum logic [1:0] {
    CAND_SKIP = 2'd0,
    CAND_FREE = 2'd1,
    CAND_WB   = 2'd2
  } cand_e;

  function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/hand_pair.sv
module hand_pair #(
  parameter int NFRAMES  = 16,
  parameter int HAND_GAP = 4,
  localparam int FW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [FW-1:0] reap_ptr,
  output logic [FW-1:0] clear_ptr
);
  localparam logic [FW-1:0] LAST = FW'(NFRAMES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reap_ptr  <= '0;
      clear_ptr <= FW'(HAND_GAP % NFRAMES);
    end else if (adv) begin
      reap_ptr  <= (reap_ptr  == LAST) ? '0 : reap_ptr  + 1'b1;
      clear_ptr <= (clear_ptr == LAST) ? '0 : clear_ptr + 1'b1;
    end
  end

  p_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(clear_ptr) + NFRAMES - int'(reap_ptr)) % NFRAMES) == (HAND_GAP % NFRAMES));
  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> int'(reap_ptr) == int'(reclaim_pkg::ring_next(int'($past(reap_ptr)), NFRAMES)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(reap_ptr) && $stable(clear_ptr));
endmodule

// File: rtl/frame_table.sv
module frame_table #(
  parameter int NFRAMES = 16,
  localparam int FW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_v,
  input  logic [FW-1:0]      ref_f,
  input  logic               ref_w,
  input  logic               done_v,
  input  logic [FW-1:0]      done_f,
  input  logic               clr_v,
  input  logic [FW-1:0]      clr_f,
  input  logic               take_free,
  input  logic               take_wb,
  input  logic [FW-1:0]      take_f,
  output logic [NFRAMES-1:0] used,
  output logic [NFRAMES-1:0] dirty,
  output logic [NFRAMES-1:0] freed,
  output logic [NFRAMES-1:0] pend
);
  for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
    logic hit_ref, hit_done, hit_clr, hit_take;
    assign hit_ref  = ref_v  && (ref_f  == FW'(i));
    assign hit_done = done_v && (done_f == FW'(i));
    assign hit_clr  = clr_v  && (clr_f  == FW'(i));
    assign hit_take = take_f == FW'(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used[i]  <= 1'b0;
        dirty[i] <= 1'b0;
        freed[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        if (hit_ref)      used[i] <= 1'b1;
        else if (hit_clr) used[i] <= 1'b0;

        if (hit_ref)                    freed[i] <= 1'b0;
        else if (take_free && hit_take) freed[i] <= 1'b1;

        if (hit_ref && ref_w) dirty[i] <= 1'b1;
        else if (hit_done)    dirty[i] <= 1'b0;

        if (hit_done)                 pend[i] <= 1'b0;
        else if (take_wb && hit_take) pend[i] <= 1'b1;
      end
    end
  end

  p_ref_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_v |=> used[$past(ref_f)] && !freed[$past(ref_f)]);
  p_write_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_v && ref_w |=> dirty[$past(ref_f)]);
  p_done_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_v && !(ref_v && ref_w && ref_f == done_f) |=> !dirty[$past(done_f)] && !pend[$past(done_f)]);
endmodule

// File: rtl/reap_decide.sv
module reap_decide #(
  parameter int NFRAMES = 16,
  localparam int FW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic [FW-1:0]      reap_ptr,
  input  logic               ref_v,
  input  logic [FW-1:0]      ref_f,
  input  logic [NFRAMES-1:0] used,
  input  logic [NFRAMES-1:0] dirty,
  input  logic [NFRAMES-1:0] freed,
  input  logic [NFRAMES-1:0] pend,
  input  logic               free_ready,
  input  logic               wb_ready,
  output logic               free_valid,
  output logic               wb_valid,
  output logic               take_free,
  output logic               take_wb,
  output logic               adv
);
  import reclaim_pkg::*;
  cand_e cand;
  logic  live_used;

  always_comb begin
    live_used = used[reap_ptr] || (ref_v && ref_f == reap_ptr);
    if (live_used || freed[reap_ptr] || pend[reap_ptr]) cand = CAND_SKIP;
    else if (dirty[reap_ptr])                           cand = CAND_WB;
    else                                                cand = CAND_FREE;
  end

  assign free_valid = scan_en && (cand == CAND_FREE);
  assign wb_valid   = scan_en && (cand == CAND_WB);
  assign take_free  = free_valid && free_ready;
  assign take_wb    = wb_valid && wb_ready;
  assign adv        = scan_en && !(free_valid && !free_ready) && !(wb_valid && !wb_ready);

  p_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(free_valid && wb_valid));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !free_valid && !wb_valid && !adv);
endmodule

// File: rtl/clock_reclaimer.sv
module clock_reclaimer #(
  parameter int NFRAMES  = 16,
  parameter int HAND_GAP = 4,
  localparam int FW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_en,
  input  logic          ref_valid,
  input  logic [FW-1:0] ref_frame,
  input  logic          ref_write,
  input  logic          wb_done_valid,
  input  logic [FW-1:0] wb_done_frame,
  output logic          free_valid,
  input  logic          free_ready,
  output logic [FW-1:0] free_frame,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [FW-1:0] wb_frame
);
  logic [FW-1:0]      reap_ptr, clear_ptr;
  logic [NFRAMES-1:0] used, dirty, freed, pend;
  logic               adv, take_free, take_wb;

  hand_pair #(.NFRAMES(NFRAMES), .HAND_GAP(HAND_GAP)) u_hands (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .reap_ptr(reap_ptr), .clear_ptr(clear_ptr)
  );

  frame_table #(.NFRAMES(NFRAMES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .ref_v(ref_valid), .ref_f(ref_frame), .ref_w(ref_write),
    .done_v(wb_done_valid), .done_f(wb_done_frame),
    .clr_v(adv), .clr_f(clear_ptr),
    .take_free(take_free), .take_wb(take_wb), .take_f(reap_ptr),
    .used(used), .dirty(dirty), .freed(freed), .pend(pend)
  );

  reap_decide #(.NFRAMES(NFRAMES)) u_decide (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .reap_ptr(reap_ptr),
    .ref_v(ref_valid), .ref_f(ref_frame),
    .used(used), .dirty(dirty), .freed(freed), .pend(pend),
    .free_ready(free_ready), .wb_ready(wb_ready),
    .free_valid(free_valid), .wb_valid(wb_valid),
    .take_free(take_free), .take_wb(take_wb), .adv(adv)
  );

  assign free_frame = reap_ptr;
  assign wb_frame   = reap_ptr;

  p_freed_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid && free_ready |=> freed[$past(free_frame)]);
  p_wb_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready && !(wb_done_valid && wb_done_frame == wb_frame)
    |=> pend[$past(wb_frame)] && !freed[$past(wb_frame)]);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && !free_ready) || (wb_valid && !wb_ready) |=> $stable(free_frame));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !(ref_valid && ref_frame == clear_ptr) |=> !used[$past(clear_ptr)]);
  p_ref_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> used[$past(ref_frame)]);
endmodule

// File: tb/sim_clock_reclaimer.sv
`timescale 1ns/1ps
module sim_clock_reclaimer;
  localparam int NF  = 16;
  localparam int GAP = 4;
  localparam int FW  = $clog2(NF);

  logic clk = 1'b0, rst_n = 1'b0;
  logic scan_en = 0, ref_valid = 0, ref_write = 0, wb_done_valid = 0;
  logic [FW-1:0] ref_frame = '0, wb_done_frame = '0;
  logic free_ready = 0, wb_ready = 0;
  logic free_valid, wb_valid;
  logic [FW-1:0] free_frame, wb_frame;

  always #4 clk = ~clk;

  clock_reclaimer #(.NFRAMES(NF), .HAND_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
    .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
    .wb_done_valid(wb_done_valid), .wb_done_frame(wb_done_frame),
    .free_valid(free_valid), .free_ready(free_ready), .free_frame(free_frame),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_frame(wb_frame)
  );

  int vectors = 0, errs = 0;
  bit m_used[NF], m_dirty[NF], m_freed[NF], m_pend[NF];
  int m_rp = 0;
  int exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  // monitor: captures accepted items at the edge, compares at the next falling edge
  logic hs_f = 0, hs_w = 0;
  logic [FW-1:0] cap_f = '0, cap_w = '0;
  always @(posedge clk) begin
    hs_f  <= free_valid && free_ready;
    hs_w  <= wb_valid && wb_ready;
    cap_f <= free_frame;
    cap_w <= wb_frame;
  end
  always @(negedge clk) begin
    if (hs_f || hs_w) begin
      int got;
      got = hs_w ? (256 + int'(cap_w)) : int'(cap_f);
      if (exp_q.size() == 0) chk(1'b0, "R4/R5 unexpected item", got, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(got == e, "R4/R5 accepted item", got, e);
      end
    end
  end

  task automatic cyc(input bit rv, input int rf, input bit rw, input bit dv, input int df,
                     input bit se, input bit fr, input bit wr, input string tag);
    int f, c;
    bit cu, skip, ef, ew, adv;
    ref_valid = rv; ref_frame = FW'(rf); ref_write = rw;
    wb_done_valid = dv; wb_done_frame = FW'(df);
    scan_en = se; free_ready = fr; wb_ready = wr;
    #1;
    f = m_rp;
    cu = m_used[f] || (rv && rf == f);
    skip = cu || m_freed[f] || m_pend[f];
    ef = se && !skip && !m_dirty[f];
    ew = se && !skip && m_dirty[f];
    chk(free_valid == ef, {tag, " free_valid"}, free_valid, ef);
    chk(wb_valid == ew, {tag, " wb_valid"}, wb_valid, ew);
    chk(!(free_valid && wb_valid), "R12 both valid", 1, 0);
    if (ef) chk(int'(free_frame) == f, {tag, " free_frame"}, free_frame, f);
    if (ew) chk(int'(wb_frame) == f, {tag, " wb_frame"}, wb_frame, f);
    adv = se && !(ef && !fr) && !(ew && !wr);
    if (ef && fr) begin exp_q.push_back(f); m_freed[f] = 1; end
    if (ew && wr) begin exp_q.push_back(256 + f); m_pend[f] = 1; end
    c = (m_rp + GAP) % NF;
    if (adv && !m_freed[c]) m_used[c] = 0;
    if (dv) begin m_dirty[df] = 0; m_pend[df] = 0; end
    if (rv) begin m_used[rf] = 1; m_freed[rf] = 0; if (rw) m_dirty[rf] = 1; end
    if (adv) m_rp = (m_rp + 1) % NF;
    @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state with scan off (also R9)
    chk(free_valid == 0 && wb_valid == 0, "R1 outputs idle after reset", free_valid, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R9");
    // R1: first candidate is frame 0; R4 clean frames freed in ring order
    for (int i = 0; i < NF; i++) cyc(0, 0, 0, 0, 0, 1, 1, 1, "R4");
    // R7: all frames marked, nothing offered
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 1, 1, 1, "R7");
    // R2: read to 2, write to 5
    cyc(1, 2, 0, 0, 0, 0, 1, 1, "R2");
    cyc(1, 5, 1, 0, 0, 0, 1, 1, "R2");
    // R8: writeback stream blocked, hands must hold on frame 5
    for (int i = 0; i < 24; i++) cyc(0, 0, 0, 0, 0, 1, 1, 0, "R8");
    chk(wb_valid == 1 && int'(wb_frame) == 5, "R8 stalled on dirty frame", wb_frame, 5);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 0, 1, 1, 1, "R5");
    // R6: completion then frame 5 becomes freeable
    cyc(0, 0, 0, 1, 5, 0, 1, 1, "R6");
    for (int i = 0; i < 2 * NF; i++) cyc(0, 0, 0, 0, 0, 1, 1, 1, "R6");
    // R11: reference lands on the reclaiming hand's frame
    cyc(1, 9, 0, 0, 0, 0, 1, 1, "R2");
    while (m_rp != 9) cyc(0, 0, 0, 0, 0, 1, 1, 1, "R10");
    cyc(1, 9, 0, 0, 0, 1, 1, 1, "R11");
    // R3: reference coincides with clearing hand
    while ((m_rp + GAP) % NF != 12) cyc(0, 0, 0, 0, 0, 1, 1, 1, "R10");
    cyc(1, 12, 0, 0, 0, 1, 1, 1, "R3");
    for (int i = 0; i < GAP + 2; i++) cyc(0, 0, 0, 0, 0, 1, 1, 1, "R3");
    // R10: mixed traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[1:0] == 2'b00, int'(lfsr[7:4]), lfsr[8], lfsr[11:9] == 3'b000, int'(lfsr[15:12]),
          lfsr[14:12] != 3'b000, lfsr[3:2] != 2'b00, lfsr[6:5] != 2'b00, "R10");
    end
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R9");
    chk(exp_q.size() == 0, "R4/R5 items left unseen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule